// File: doc/BRIEF.md
# Block Transfer Command Sequencer

This host-side sequencer takes a single request (direction, starting byte location, number of blocks) and produces the ordered series of commands that a managed flash memory card needs to move that data. It picks the one-block or the many-block command for the direction. It turns the byte location into the argument form that matches the card's capacity class. For many-block writes it can announce the block count ahead of time. When a transfer has no preset length, it closes the transfer with a stop command.

Each command is offered on a valid/ready handshake to a command issuer that is outside this block. Data movement is also outside the block: a data-path engine pulses `blkDone` once for every block it completes, and the sequencer counts these pulses to know when the transfer has reached its end. Requests that cannot be served are refused with an error pulse, and no command is sent for them. Every accepted request ends in exactly one `done` pulse or one `error` pulse.

Top module: `xferCmdSeq`

## Requirements
- R1: A read of one block issues exactly one command, index 17, with the converted address as its argument, followed by `done`.
- R2: A read of two or more blocks issues index 18 with the converted address, then index 12 with argument 0, then `done`.
- R3: A write of one block issues exactly one command, index 24, with the converted address, followed by `done`.
- R4: A write of two or more blocks with `presetCount` high issues index 23 (argument = block count, zero-extended), then index 25 with the converted address, and no index 12. `done` follows the last block.
- R5: A write of two or more blocks with `presetCount` low issues index 25 with the converted address, then index 12 with argument 0, then `done`.
- R6: With `sectorMode` low the argument is the byte address itself. With `sectorMode` high it is the byte address divided by 512.
- R7: Index 12 is offered only after `blkDone` has reported every requested block, and `done` follows its acceptance.
- R8: The block raises `error` and sends no command for any of these requests: a sector-mode address that is not a multiple of 512; a byte-mode address of 2^32 or more; a block count of 0; a write while `devSelected` is low.
- R9: A request is taken only in a cycle where `reqReady` is high, which is exactly when the block is idle. `reqValid` while busy has no effect.
- R10: Each taken request produces exactly one one-cycle pulse of `done` or `error`, never both at once. `reqReady` is high again in the next cycle.
- R11: A command stays offered with unchanged index and argument until the cycle in which `cmdReady` is high.
- R12: A `blkDone` in the same cycle as the acceptance of the data-transfer command counts as a completed block. A `blkDone` while idle or while the count-preset command is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Idle; a request is taken this cycle if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqByteAddr | input | ADDR_W | Starting location in bytes |
| reqBlocks | input | CNT_W | Number of 512-byte blocks |
| sectorMode | input | 1 | Capacity class: 1 = sector arguments, 0 = byte arguments |
| presetCount | input | 1 | Many-block writes announce their count instead of being stopped |
| devSelected | input | 1 | Card is already in the transfer state |
| cmdValid | output | 1 | Command offered to the issuer |
| cmdReady | input | 1 | Issuer accepts the offered command |
| cmdIndex | output | 6 | Command index |
| cmdArg | output | 32 | Command argument |
| blkDone | input | 1 | Data path finished one block |
| done | output | 1 | Request completed (one-cycle pulse) |
| error | output | 1 | Request refused (one-cycle pulse) |

## Verification
The case that needs care is a block completion that lands in the same cycle as the acceptance of the transfer command. This can happen when the data path is fast. The bench provokes it by raising `blkDone` together with `cmdReady` for index 17, 18, 24 or 25, including one-block requests where that single pulse ends the transfer. It judges the result by the cycle in which index 12 is accepted, which must come exactly when the bench has delivered the full block count, and by `done` appearing with no further pulses. A second overlap is a new `reqValid` that is held through a whole transfer and through its `done` cycle. The expected command queue must match exactly, with no extra command.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

  localparam logic [5:0] IDX_RD_ONE  = 6'd17;
  localparam logic [5:0] IDX_RD_MANY = 6'd18;
  localparam logic [5:0] IDX_WR_ONE  = 6'd24;
  localparam logic [5:0] IDX_WR_MANY = 6'd25;
  localparam logic [5:0] IDX_SETCNT  = 6'd23;
  localparam logic [5:0] IDX_STOP    = 6'd12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRESET, ST_XFER, ST_DATA, ST_STOP, ST_DONE, ST_ERR
  } seqState_t;

  typedef enum logic [1:0] {
    PH_XFER, PH_PRESET, PH_STOP
  } cmdPhase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic      load;
    logic      countBlk;
    cmdPhase_t phase;
  } dpCtl_t;

  // datapath -> control status
  typedef struct packed {
    logic reject;     // combinational, from the pending request
    logic wantPreset; // combinational, from the pending request
    logic needStop;   // registered at load
    logic lastBlk;    // one block left
  } dpStat_t;

endpackage

// File: rtl/xferSeqDatapath.sv
module xferSeqDatapath
  import xfer_seq_pkg::*;
#(
  parameter int ADDR_W = 40,  // at least 10
  parameter int CNT_W  = 16   // at most 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqByteAddr,
  input  logic [CNT_W-1:0]  reqBlocks,
  input  logic              sectorMode,
  input  logic              presetCount,
  input  logic              devSelected,
  output dpStat_t           stat,
  output logic [5:0]        cmdIndex,
  output logic [31:0]       cmdArg
);

  logic [31:0] byteArg, sectArg, cntArg;
  logic        byteOver, sectOver;

  // argument forms of the incoming address
  generate
    if (ADDR_W > 32) begin : g_byteWide
      assign byteArg  = reqByteAddr[31:0];
      assign byteOver = |reqByteAddr[ADDR_W-1:32];
    end else if (ADDR_W == 32) begin : g_byteExact
      assign byteArg  = reqByteAddr;
      assign byteOver = 1'b0;
    end else begin : g_byteNarrow
      assign byteArg  = {{(32-ADDR_W){1'b0}}, reqByteAddr};
      assign byteOver = 1'b0;
    end

    if (ADDR_W > 41) begin : g_sectWide
      assign sectArg  = reqByteAddr[40:9];
      assign sectOver = |reqByteAddr[ADDR_W-1:41];
    end else if (ADDR_W == 41) begin : g_sectExact
      assign sectArg  = reqByteAddr[40:9];
      assign sectOver = 1'b0;
    end else begin : g_sectNarrow
      assign sectArg  = {{(41-ADDR_W){1'b0}}, reqByteAddr[ADDR_W-1:9]};
      assign sectOver = 1'b0;
    end
  endgenerate

  logic misaligned, multiReq;
  assign misaligned = sectorMode & (|reqByteAddr[8:0]);
  assign multiReq   = (reqBlocks > CNT_W'(1));

  assign stat.reject = misaligned
                     | (sectorMode ? sectOver : byteOver)
                     | (reqBlocks == '0)
                     | (reqWrite & ~devSelected);
  assign stat.wantPreset = reqWrite & presetCount & multiReq;

  // per-request state
  logic              wrReg, multiReg, stopReg;
  logic [31:0]       argReg;
  logic [CNT_W-1:0]  cntReg, remain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrReg    <= 1'b0;
      multiReg <= 1'b0;
      stopReg  <= 1'b0;
      argReg   <= '0;
      cntReg   <= '0;
      remain   <= '0;
    end else if (ctl.load) begin
      wrReg    <= reqWrite;
      multiReg <= multiReq;
      stopReg  <= multiReq & ~(reqWrite & presetCount);
      argReg   <= sectorMode ? sectArg : byteArg;
      cntReg   <= reqBlocks;
      remain   <= reqBlocks;
    end else if (ctl.countBlk) begin
      remain   <= remain - CNT_W'(1);
    end
  end

  assign stat.needStop = stopReg;
  assign stat.lastBlk  = (remain == CNT_W'(1));

  generate
    if (CNT_W < 32) begin : g_cntPad
      assign cntArg = {{(32-CNT_W){1'b0}}, cntReg};
    end else begin : g_cntFull
      assign cntArg = cntReg[31:0];
    end
  endgenerate

  always_comb begin
    unique case (ctl.phase)
      PH_PRESET: begin cmdIndex = IDX_SETCNT; cmdArg = cntArg; end
      PH_STOP:   begin cmdIndex = IDX_STOP;   cmdArg = '0;     end
      default: begin
        cmdArg = argReg;
        if (wrReg) cmdIndex = multiReg ? IDX_WR_MANY : IDX_WR_ONE;
        else       cmdIndex = multiReg ? IDX_RD_MANY : IDX_RD_ONE;
      end
    endcase
  end

endmodule

// File: rtl/xferSeqControl.sv
module xferSeqControl
  import xfer_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    cmdReady,
  input  logic    blkDone,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    reqReady,
  output logic    cmdValid,
  output logic    done,
  output logic    error
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState    = state;
    ctl.load     = 1'b0;
    ctl.countBlk = 1'b0;
    ctl.phase    = PH_XFER;
    cmdValid     = 1'b0;
    reqReady     = 1'b0;
    done         = 1'b0;
    error        = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.load = 1'b1;
          if (stat.reject)          nextState = ST_ERR;
          else if (stat.wantPreset) nextState = ST_PRESET;
          else                      nextState = ST_XFER;
        end
      end
      ST_PRESET: begin
        ctl.phase = PH_PRESET;
        cmdValid  = 1'b1;
        if (cmdReady) nextState = ST_XFER;
      end
      ST_XFER: begin
        cmdValid = 1'b1;
        if (cmdReady) begin
          nextState = ST_DATA;
          if (blkDone) begin
            ctl.countBlk = 1'b1;
            if (stat.lastBlk) nextState = stat.needStop ? ST_STOP : ST_DONE;
          end
        end
      end
      ST_DATA: begin
        if (blkDone) begin
          ctl.countBlk = 1'b1;
          if (stat.lastBlk) nextState = stat.needStop ? ST_STOP : ST_DONE;
        end
      end
      ST_STOP: begin
        ctl.phase = PH_STOP;
        cmdValid  = 1'b1;
        if (cmdReady) nextState = ST_DONE;
      end
      ST_DONE: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      ST_ERR: begin
        error     = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/xferCmdSeq.sv
module xferCmdSeq
  import xfer_seq_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqByteAddr,
  input  logic [CNT_W-1:0]  reqBlocks,
  input  logic              sectorMode,
  input  logic              presetCount,
  input  logic              devSelected,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [5:0]        cmdIndex,
  output logic [31:0]       cmdArg,
  input  logic              blkDone,
  output logic              done,
  output logic              error
);

  dpCtl_t  ctl;
  dpStat_t stat;

  xferSeqControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cmdReady (cmdReady),
    .blkDone  (blkDone),
    .stat     (stat),
    .ctl      (ctl),
    .reqReady (reqReady),
    .cmdValid (cmdValid),
    .done     (done),
    .error    (error)
  );

  xferSeqDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqWrite    (reqWrite),
    .reqByteAddr (reqByteAddr),
    .reqBlocks   (reqBlocks),
    .sectorMode  (sectorMode),
    .presetCount (presetCount),
    .devSelected (devSelected),
    .stat        (stat),
    .cmdIndex    (cmdIndex),
    .cmdArg      (cmdArg)
  );

endmodule

// File: rtl/xferCmdSeqChecker.sv
module xferCmdSeqChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        cmdValid,
  input logic        cmdReady,
  input logic [5:0]  cmdIndex,
  input logic [31:0] cmdArg,
  input logic        done,
  input logic        error
);

  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdIndex) && $stable(cmdArg));

  assert_done_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  assert_back_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |=> reqReady && !done && !error);

  assert_cmd_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !reqReady);

  assert_preset_then_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && cmdIndex == 6'd23 |=> cmdValid && cmdIndex == 6'd25);

  assert_stop_then_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && cmdIndex == 6'd12 |=> done);

endmodule

bind xferCmdSeq xferCmdSeqChecker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .cmdIndex (cmdIndex),
  .cmdArg   (cmdArg),
  .done     (done),
  .error    (error)
);

// File: tb/xferCmdSeq_bench.sv
`timescale 1ns/1ps
module xferCmdSeq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [39:0] reqByteAddr = '0;
  logic [15:0] reqBlocks = '0;
  logic        sectorMode = 1'b0;
  logic        presetCount = 1'b0;
  logic        devSelected = 1'b0;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic [5:0]  cmdIndex;
  logic [31:0] cmdArg;
  logic        blkDone = 1'b0;
  logic        done, error;

  always #2.5 clk = ~clk;

  xferCmdSeq u_xferCmdSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqByteAddr(reqByteAddr), .reqBlocks(reqBlocks),
    .sectorMode(sectorMode), .presetCount(presetCount), .devSelected(devSelected),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdIndex(cmdIndex), .cmdArg(cmdArg),
    .blkDone(blkDone), .done(done), .error(error)
  );

  int errs = 0;
  int checks = 0;
  logic [5:0]  expIdx[$];
  logic [31:0] expArg[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one request, modelled from the requirements and served cycle by cycle
  task automatic runReq(input string req, input bit wr, input logic [39:0] addr,
                        input int nb, input bit sect, input bit preset, input bit sel,
                        input int rdyDelay, input int gap, input bit coincide,
                        input bit busyPoke);
    bit expErr, multi, xferSent, finished;
    logic [31:0] arg;
    int sent, waitCnt, gapCnt, cyc;
    logic [5:0] idx;
    expErr = (sect && addr[8:0] != 9'd0) || (!sect && addr[39:32] != 8'd0) ||
             nb == 0 || (wr && !sel);
    multi = nb > 1;
    arg = sect ? 32'(addr >> 9) : addr[31:0];
    expIdx.delete(); expArg.delete();
    if (!expErr) begin
      if (wr && multi && preset) begin expIdx.push_back(6'd23); expArg.push_back(32'(nb)); end
      expIdx.push_back(wr ? (multi ? 6'd25 : 6'd24) : (multi ? 6'd18 : 6'd17));
      expArg.push_back(arg);
      if (multi && !(wr && preset)) begin expIdx.push_back(6'd12); expArg.push_back(32'd0); end
    end
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqByteAddr = addr; reqBlocks = 16'(nb);
    sectorMode = sect; presetCount = preset; devSelected = sel;
    @(negedge clk);
    if (busyPoke) begin reqWrite = !wr; reqByteAddr = 40'h400; reqBlocks = 16'd7; end
    else reqValid = 1'b0;
    sent = 0; waitCnt = 0; gapCnt = 0; xferSent = 0; finished = 0; cyc = 0;
    while (!finished) begin
      cmdReady = 1'b0; blkDone = 1'b0;
      if (done || error) begin
        check(error == expErr && done == !expErr, req, "outcome error flag", error, expErr);
        check(expIdx.size() == 0, busyPoke ? "R9" : req, "commands left unissued", expIdx.size(), 0);
        if (!expErr) check(sent == nb, "R7", "blocks before done", sent, nb);
        reqValid = 1'b0;
        finished = 1;
      end else if (cmdValid) begin
        waitCnt++;
        if (waitCnt > rdyDelay) begin
          waitCnt = 0;
          cmdReady = 1'b1;
          if (expIdx.size() == 0) begin
            check(1'b0, busyPoke ? "R9" : req, "unexpected command", cmdIndex, 0);
          end else begin
            idx = expIdx.pop_front();
            check(cmdIndex == idx, req, "command index", cmdIndex, idx);
            arg = expArg.pop_front();
            check(cmdArg == arg, "R6", "command argument", cmdArg, arg);
          end
          if (cmdIndex == 6'd12) check(sent == nb, "R7", "blocks before stop", sent, nb);
          if (cmdIndex == 6'd17 || cmdIndex == 6'd18 || cmdIndex == 6'd24 || cmdIndex == 6'd25) begin
            xferSent = 1;
            if (coincide) begin blkDone = 1'b1; sent++; gapCnt = 0; end
          end
        end
      end else if (xferSent && sent < nb) begin
        gapCnt++;
        if (gapCnt >= gap) begin blkDone = 1'b1; sent++; gapCnt = 0; end
      end
      cyc++;
      if (cyc > 3000) begin
        check(1'b0, req, "request never finished", cyc, 0);
        finished = 1;
      end
      @(negedge clk);
    end
    cmdReady = 1'b0; blkDone = 1'b0;
    check(reqReady && !done && !error && !cmdValid, "R10", "idle after pulse",
          {reqReady, done, error, cmdValid}, 4'b1000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !cmdValid && !done && !error, "R10", "reset state",
          {reqReady, cmdValid, done, error}, 4'b1000);

    runReq("R1", 0, 40'h1234, 1, 0, 0, 0, 0, 2, 0, 0);
    runReq("R2", 0, 40'h40000, 4, 1, 0, 0, 2, 3, 0, 0);
    runReq("R3", 1, 40'h0_0123_4600, 1, 1, 0, 1, 1, 1, 0, 0);
    runReq("R4", 1, 40'h800, 3, 1, 1, 1, 0, 2, 0, 0);
    runReq("R5", 1, 40'hABCD, 2, 0, 0, 1, 1, 1, 1, 0);
    runReq("R12", 0, 40'hFF_FFFF_FE00, 3, 1, 0, 0, 0, 1, 1, 0);
    runReq("R12", 1, 40'h200, 1, 1, 0, 1, 0, 1, 1, 0);
    runReq("R4", 1, 40'h1000, 2, 1, 1, 1, 3, 1, 1, 0);
    runReq("R8", 0, 40'h201, 2, 1, 0, 0, 0, 1, 0, 0);
    runReq("R8", 1, 40'h0, 2, 0, 0, 0, 0, 1, 0, 0);
    runReq("R8", 0, 40'h0, 0, 0, 0, 0, 0, 1, 0, 0);
    runReq("R8", 0, 40'h1_0000_0000, 1, 0, 0, 0, 0, 1, 0, 0);
    runReq("R9", 0, 40'h600, 3, 1, 0, 0, 1, 2, 0, 1);

    // stray completions while idle must not be counted (R12)
    @(negedge clk); blkDone = 1'b1;
    repeat (3) @(negedge clk);
    blkDone = 1'b0;
    check(reqReady && !cmdValid, "R12", "stray blkDone left idle",
          {reqReady, cmdValid}, 2'b10);
    runReq("R12", 0, 40'h0, 2, 0, 0, 0, 0, 2, 0, 0);
    runReq("R6", 0, 40'hFFFF_FFFF, 1, 0, 0, 0, 0, 1, 0, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule